// File: doc/BRIEF.md
# Per-Warp Hit Ratio Classifier

This block watches the stream of shared-cache lookup results and keeps, for every warp, a count of its lookups and of how many of them hit. Once per sampling window it turns each warp's hit/lookup ratio into one of five ordered classes. The classes run from warps that always hit to warps that never hit, and the counters then start over. A warp's class therefore follows its behaviour within the current program phase.

A request path asks the block about a warp through a combinational query port. The block answers with the warp's current class and with a flag that says whether that warp's requests should go straight to memory instead of through the shared cache. The comparisons against the class thresholds use shifts and adds on the two counts, so no divider is needed.

Top module: `warp_hit_classifier`

## Requirements
- R1: After reset every warp is in class 2 (balanced) and its bypass flag is 0.
- R2: Each lookup with `lk_valid` high adds one to the access count of warp `lk_warp` only, and adds one to that warp's hit count when `lk_hit` is 1. The counts of all other warps do not change.
- R3: Class codes are 0 all-hit, 1 mostly-hit, 2 balanced, 3 mostly-miss, 4 all-miss. A warp with at least one access and no misses gets 0. A warp with at least one access and no hits gets 4.
- R4: Any other warp with 10·hits ≥ 7·accesses (a ratio of at least 0.7) gets class 1.
- R5: Any remaining warp with 5·hits ≤ accesses (a ratio of at most 0.2) gets class 3. Every other warp gets class 2.
- R6: A warp with no accesses in a window keeps the class it already had.
- R7: Classes change only on the last cycle of each `INTERVAL`-cycle window. Cycles are counted from 0 after reset, so the last cycle of a window has count INTERVAL-1 modulo INTERVAL. At all other times the classes hold.
- R8: On that last cycle all counts clear, and any lookup presented in the same cycle is discarded.
- R9: Counts are `CNT_W` bits wide. Once a warp's access count reaches its maximum, that warp's further lookups are ignored for the rest of the window.
- R10: `q_bypass` is 1 exactly when the queried warp's class is 3 or 4.
- R11: `q_class` and `q_bypass` follow `q_warp` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A shared-cache lookup result is present |
| lk_warp | input | $clog2(NUM_WARPS) | Warp that issued the lookup |
| lk_hit | input | 1 | 1 if the lookup hit |
| q_warp | input | $clog2(NUM_WARPS) | Warp being queried |
| q_class | output | 3 | Current class of the queried warp |
| q_bypass | output | 1 | Requests of the queried warp should bypass the shared cache |

## Verification
The bench builds the block with four warps, a 1024-cycle window and the default 8-bit counts. With only four warps, every hit/access pair with 1 to 10 accesses can be swept in a few windows, and each result is checked against thresholds computed in the bench, including the exact 0.7 and 0.2 boundaries. The 1024-cycle window leaves room for several hundred lookups to a single warp, so saturation can be driven in a way that changes the resulting class. It also leaves room for the lookup discarded on the window's last cycle, and for empty windows that must keep each warp's class.

// File: rtl/warp_hit_classifier.sv
module warp_hit_classifier #(
  parameter int NUM_WARPS = 32,
  parameter int CNT_W     = 8,
  parameter int INTERVAL  = 4096,
  localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [WW-1:0] lk_warp,
  input  logic          lk_hit,
  input  logic [WW-1:0] q_warp,
  output logic [2:0]    q_class,
  output logic          q_bypass
);

  localparam logic [2:0] C_ALL_HIT  = 3'd0;
  localparam logic [2:0] C_MOST_HIT = 3'd1;
  localparam logic [2:0] C_BAL      = 3'd2;
  localparam logic [2:0] C_MOST_MIS = 3'd3;
  localparam logic [2:0] C_ALL_MIS  = 3'd4;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [TW-1:0]    tick;
  logic             win_end;
  logic [CNT_W-1:0] hit_q [NUM_WARPS];
  logic [CNT_W-1:0] acc_q [NUM_WARPS];
  logic [2:0]       cls_q [NUM_WARPS];

  function automatic logic [2:0] classify(input logic [CNT_W-1:0] h, input logic [CNT_W-1:0] a);
    logic [CNT_W+3:0] he, ae, h10, a7, h5;
    he  = {4'b0, h};
    ae  = {4'b0, a};
    h10 = (he << 3) + (he << 1);
    a7  = (ae << 3) - ae;
    h5  = (he << 2) + he;
    if (h == a)          return C_ALL_HIT;
    else if (h == '0)    return C_ALL_MIS;
    else if (h10 >= a7)  return C_MOST_HIT;
    else if (h5 <= ae)   return C_MOST_MIS;
    else                 return C_BAL;
  endfunction

  assign win_end = (tick == TW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tick <= '0;
    else if (win_end) tick <= '0;
    else              tick <= tick + 1'b1;
  end

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic sel;
    assign sel = lk_valid && (lk_warp == WW'(w)) && (acc_q[w] != CMAX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q[w] <= '0;
        acc_q[w] <= '0;
        cls_q[w] <= C_BAL;
      end else if (win_end) begin
        hit_q[w] <= '0;
        acc_q[w] <= '0;
        if (acc_q[w] != '0) cls_q[w] <= classify(hit_q[w], acc_q[w]);
      end else if (sel) begin
        acc_q[w] <= acc_q[w] + 1'b1;
        hit_q[w] <= hit_q[w] + CNT_W'(lk_hit);
      end
    end
  end

  assign q_class  = (int'(q_warp) < NUM_WARPS) ? cls_q[q_warp] : C_BAL;
  assign q_bypass = (q_class == C_MOST_MIS) || (q_class == C_ALL_MIS);

endmodule

module warp_hit_classifier_chk #(
  parameter int NW = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          win_end,
  input logic [CW-1:0] hit_q [NW],
  input logic [CW-1:0] acc_q [NW],
  input logic [2:0]    q_class,
  input logic          q_bypass
);

  a_r3_class_range: assert property (@(posedge clk) disable iff (!rst_n)
    q_class <= 3'd4);

  a_r10_bypass_class: assert property (@(posedge clk) disable iff (!rst_n)
    q_bypass == (q_class >= 3'd3));

  for (genvar i = 0; i < NW; i++) begin : g_chk
    a_r2_hits_within_acc: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q[i] <= acc_q[i]);

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> (acc_q[i] == $past(acc_q[i])) || (acc_q[i] == $past(acc_q[i]) + 1'b1));

    a_r8_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (acc_q[i] == '0) && (hit_q[i] == '0));

    a_r9_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q[i] == {CW{1'b1}} && !win_end) |=> (acc_q[i] == {CW{1'b1}}) && $stable(hit_q[i]));
  end

endmodule

bind warp_hit_classifier warp_hit_classifier_chk #(.NW(NUM_WARPS), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_end(win_end), .hit_q(hit_q), .acc_q(acc_q),
  .q_class(q_class), .q_bypass(q_bypass)
);

// File: tb/warp_hit_classifier_test.sv
`timescale 1ns/1ps
module warp_hit_classifier_test;
  localparam int NW = 4;
  localparam int IV = 1024;
  localparam int SAT = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lk_valid = 1'b0;
  logic [1:0] lk_warp = '0;
  logic       lk_hit = 1'b0;
  logic [1:0] q_warp = '0;
  logic [2:0] q_class;
  logic       q_bypass;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cls [NW];
  int wh [NW];
  int wm [NW];

  always #10 clk = ~clk;

  warp_hit_classifier #(.NUM_WARPS(NW), .CNT_W(8), .INTERVAL(IV)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_warp(lk_warp), .lk_hit(lk_hit),
    .q_warp(q_warp), .q_class(q_class), .q_bypass(q_bypass)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input int w, input logic h);
    lk_valid = v;
    lk_warp  = 2'(w);
    lk_hit   = h;
    @(posedge clk);
    #2;
  endtask

  function automatic int model_class(input int h, input int m, input int prev);
    int a, eh;
    a  = (h + m > SAT) ? SAT : h + m;
    eh = (h > a) ? a : h;
    if (a == 0)               return prev;
    if (eh == a)              return 0;
    if (eh == 0)              return 4;
    if (10 * eh >= 7 * a)     return 1;
    if (5 * eh <= a)          return 3;
    return 2;
  endfunction

  function automatic string tag_of(input int h, input int m, input int c);
    if (h + m == 0)          return "R6";
    if (h + m > SAT)         return "R9";
    if (c == 0 || c == 4)    return "R3";
    if (c == 1)              return "R4";
    return "R5";
  endfunction

  task automatic query_all(input string tag_override);
    for (int w = 0; w < NW; w++) begin
      q_warp = 2'(w);
      #1;
      check((tag_override != "") ? tag_override : "R11", q_class, exp_cls[w]);
      check("R10", q_bypass, (exp_cls[w] >= 3) ? 1 : 0);
    end
  endtask

  task automatic run_window(input int drop_w);
    int used;
    used = 0;
    for (int w = 0; w < NW; w++) begin
      for (int k = 0; k < wh[w]; k++) begin step(1'b1, w, 1'b1); used++; end
      for (int k = 0; k < wm[w]; k++) begin step(1'b1, w, 1'b0); used++; end
    end
    while (used < IV - 1) begin step(1'b0, 0, 1'b0); used++; end
    query_all("R7");
    if (drop_w >= 0) step(1'b1, drop_w, 1'b0);
    else             step(1'b0, 0, 1'b0);
    lk_valid = 1'b0;
    for (int w = 0; w < NW; w++) begin
      int c;
      c = model_class(wh[w], wm[w], exp_cls[w]);
      exp_cls[w] = c;
      q_warp = 2'(w);
      #1;
      check(tag_of(wh[w], wm[w], c), q_class, c);
      check("R10", q_bypass, (c >= 3) ? 1 : 0);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int hs [$];
    int as [$];
    for (int w = 0; w < NW; w++) exp_cls[w] = 2;
    repeat (3) @(posedge clk);
    #2;
    query_all("R1");
    rst_n = 1'b1;

    for (int a = 1; a <= 10; a++)
      for (int h = 0; h <= a; h++) begin hs.push_back(h); as.push_back(a); end
    for (int i = 0; i < hs.size(); i += NW) begin
      for (int w = 0; w < NW; w++) begin
        if (i + w < hs.size()) begin wh[w] = hs[i + w]; wm[w] = as[i + w] - hs[i + w]; end
        else begin wh[w] = 0; wm[w] = 0; end
      end
      run_window(-1);
    end

    wh = '{70, 69, 20, 21}; wm = '{30, 31, 80, 79};
    run_window(-1);

    wh = '{0, 0, 0, 0}; wm = '{0, 0, 0, 0};
    run_window(-1);

    wh = '{200, 300, 0, 0}; wm = '{100, 0, 0, 300};
    run_window(-1);

    wh = '{5, 0, 1, 4}; wm = '{0, 3, 4, 6};
    run_window(0);
    check("R8", q_class, exp_cls[NW - 1]);

    wh = '{0, 2, 0, 0}; wm = '{0, 1, 0, 0};
    run_window(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule